// File: doc/BRIEF.md
# Multistage Cascaded Watchdog Timer

This block watches over a processor with a chain of countdown stages, three by default. Software enables it, gives each stage its own timeout period and then kicks it at regular intervals. Each valid kick reloads the first stage. If the kicks stop, the first stage runs out. It then raises its own corrective-action pulse and starts the second stage. Each later stage does the same in turn. When the last stage runs out, it raises a system restart request and starts nothing further.

Only the first stage can be kicked. Once it has expired, the escalation cannot be stopped by kicking. Software can end it only by disabling the watchdog, and a synchronous reset also ends it. Disabling stops every stage, clears the counters and silences every action output. Enabling again starts a fresh run from the first stage. All behaviour is in one clock domain. The period registers are as wide as the write data bus.

Top module: `wdog_cascade`

## Requirements
- R1: After the synchronous reset, the watchdog is disabled and every action output and the restart request are low. Every period register holds DEFAULT_PERIOD (1000).
- R2: Register decode on a write: address 0 is control, and bit 0 = 1 enables. Writing 1 while disabled loads stage 0 with its period on that same edge. Address 1 is the kick location. Address 2+i is the 16-bit period of stage i.
- R3: A stage started on clock edge E with period P expires on edge E+P+1. On that same edge the next stage loads its own period. At most one stage runs at any time, and at most one action pulse is high.
- R4: When the final stage expires, `restartReq` rises and no stage runs afterwards.
- R5: When an intermediate stage i expires, `actPulse[i]` is high for exactly one clock cycle.
- R6: `restartReq` stays high until the synchronous reset or a write that disables the watchdog.
- R7: A kick write of exactly 16'h005A while stage 0 runs reloads stage 0 on that edge. Its expiry then moves to kick edge + P0 + 1.
- R8: A kick write of any other value does not change the timing of stage 0.
- R9: A kick written after stage 0 has expired has no effect on the later stages or on the restart request.
- R10: A control write with bit 0 = 0 stops every stage and forces every action output and `restartReq` low on that edge. A later enable starts again from stage 0, and stage 0 accepts kicks again.
- R11: A stage with period 0 expires on the edge after it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (4) | Register write address |
| wrData | input | CNT_W (16) | Register write data |
| actPulse | output | NUM_STAGES-1 (2) | One-cycle corrective-action pulses, one per intermediate stage |
| restartReq | output | 1 | Sticky system restart request from the final stage |

## Verification
The assertions check on every cycle the properties that hold at all times. At most one stage runs. Action pulses last one cycle, and each one coincides with the next stage running. The restart request is sticky and leaves no stage running. A disabled watchdog is completely silent. Only the bench's scenarios can show the exact expiry cycles for given periods. They also show that a valid kick moves the deadline while a wrong key does not. Further scenarios show that a late kick leaves the escalation unchanged, that re-enabling after a stop starts the sequence afresh, and that zero periods and the default periods behave as required.

// File: rtl/wdog_cascade_pkg.sv
package wdog_cascade_pkg;

  // Per-stage command from control to the counter datapath
  typedef struct packed {
    logic load;  // load the stage period into its counter
    logic dec;   // count down by one
    logic clr;   // force the counter to zero
  } stageCmd_t;

  localparam int CTRL_ADDR   = 0;
  localparam int KICK_ADDR   = 1;
  localparam int PERIOD_BASE = 2;

endpackage

// File: rtl/wdog_cascade_dp.sv
module wdog_cascade_dp
  import wdog_cascade_pkg::*;
#(
  parameter int NUM_STAGES     = 3,
  parameter int CNT_W          = 16,
  parameter int ADDR_W         = 4,
  parameter int DEFAULT_PERIOD = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [CNT_W-1:0]             wrData,
  input  stageCmd_t [NUM_STAGES-1:0]   cmd,
  output logic [NUM_STAGES-1:0]        cntZero
);

  localparam logic [CNT_W-1:0] RESET_PERIOD = CNT_W'(DEFAULT_PERIOD);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PERIOD_BASE + g);

    logic [CNT_W-1:0] periodReg;
    logic [CNT_W-1:0] cntReg;
    logic             perWr;

    assign perWr = wrEn && (wrAddr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        periodReg <= RESET_PERIOD;
      end else if (perWr) begin
        periodReg <= wrData;
      end
    end

    // A load uses the period held before any write on the same edge
    always_ff @(posedge clk) begin
      if (rst) begin
        cntReg <= '0;
      end else if (cmd[g].clr) begin
        cntReg <= '0;
      end else if (cmd[g].load) begin
        cntReg <= periodReg;
      end else if (cmd[g].dec) begin
        cntReg <= cntReg - 1'b1;
      end
    end

    assign cntZero[g] = (cntReg == '0);
  end

endmodule

// File: rtl/wdog_cascade_ctrl.sv
module wdog_cascade_ctrl
  import wdog_cascade_pkg::*;
#(
  parameter int               NUM_STAGES = 3,
  parameter int               CNT_W      = 16,
  parameter int               ADDR_W     = 4,
  parameter logic [CNT_W-1:0] KICK_KEY   = 16'h005A
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [CNT_W-1:0]            wrData,
  input  logic [NUM_STAGES-1:0]       cntZero,
  output stageCmd_t [NUM_STAGES-1:0]  cmd,
  output logic [NUM_STAGES-1:0]       stageRun,
  output logic                        enState,
  output logic [NUM_STAGES-2:0]       actPulse,
  output logic                        restartReq
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_ADDR);

  logic                  enReg;
  logic [NUM_STAGES-1:0] runReg;
  logic [NUM_STAGES-2:0] actReg;
  logic                  restartReg;

  logic ctrlWr, startReq, stopReq, kickHit;
  logic [NUM_STAGES-1:0] expire;
  logic [NUM_STAGES-1:0] loadV;

  assign ctrlWr   = wrEn && (wrAddr == CTRL_A);
  assign startReq = ctrlWr && wrData[0] && !enReg;
  assign stopReq  = ctrlWr && !wrData[0];
  // Kicks only reach stage 0, and only while it is counting
  assign kickHit  = wrEn && (wrAddr == KICK_A) && (wrData == KICK_KEY)
                    && enReg && runReg[0];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gCmd
    if (g == 0) begin : gFirst
      assign expire[g] = runReg[g] && cntZero[g] && !kickHit;
      assign loadV[g]  = startReq || kickHit;
    end else begin : gLater
      assign expire[g] = runReg[g] && cntZero[g];
      assign loadV[g]  = expire[g-1];
    end
    assign cmd[g].load = loadV[g] && !stopReq;
    assign cmd[g].dec  = runReg[g] && !cntZero[g] && !loadV[g];
    assign cmd[g].clr  = stopReq;
  end

  always_ff @(posedge clk) begin
    if (rst || stopReq) begin
      enReg      <= 1'b0;
      runReg     <= '0;
      actReg     <= '0;
      restartReg <= 1'b0;
    end else begin
      if (startReq) begin
        enReg <= 1'b1;
      end
      runReg     <= (runReg & ~expire) | loadV;
      actReg     <= expire[NUM_STAGES-2:0];
      restartReg <= restartReg | expire[NUM_STAGES-1];
    end
  end

  assign stageRun   = runReg;
  assign enState    = enReg;
  assign actPulse   = actReg;
  assign restartReq = restartReg;

endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
  import wdog_cascade_pkg::*;
#(
  parameter int               NUM_STAGES     = 3,
  parameter int               CNT_W          = 16,
  parameter int               ADDR_W         = 4,
  parameter int               DEFAULT_PERIOD = 1000,
  parameter logic [CNT_W-1:0] KICK_KEY       = 16'h005A
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [NUM_STAGES-2:0] actPulse,
  output logic                  restartReq
);

  localparam int ADDR_SLOTS = PERIOD_BASE + NUM_STAGES;

  initial begin
    if (NUM_STAGES < 2) $error("wdog_cascade: NUM_STAGES must be at least 2");
    if (ADDR_SLOTS > (1 << ADDR_W)) $error("wdog_cascade: ADDR_W too narrow");
  end

  stageCmd_t [NUM_STAGES-1:0] cmd;
  logic [NUM_STAGES-1:0]      cntZero;
  logic [NUM_STAGES-1:0]      stageRun;
  logic                       enState;

  wdog_cascade_ctrl #(
    .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .KICK_KEY(KICK_KEY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntZero(cntZero), .cmd(cmd), .stageRun(stageRun), .enState(enState),
    .actPulse(actPulse), .restartReq(restartReq)
  );

  wdog_cascade_dp #(
    .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .DEFAULT_PERIOD(DEFAULT_PERIOD)
  ) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .cntZero(cntZero)
  );

endmodule

// File: rtl/wdog_cascade_chk.sv
module wdog_cascade_chk #(
  parameter int NUM_STAGES = 3,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [CNT_W-1:0]      wrData,
  input logic [NUM_STAGES-2:0] actPulse,
  input logic                  restartReq,
  input logic [NUM_STAGES-1:0] stageRun,
  input logic                  enState
);

  logic stopWr;
  assign stopWr = wrEn && (wrAddr == '0) && !wrData[0];

  AST_ONE_STAGE_RUNS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stageRun)); // R3
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0(actPulse)); // R3
  AST_RESTART_STICKY: assert property (@(posedge clk) disable iff (rst)
    restartReq && !stopWr |=> restartReq); // R6
  AST_RESTART_ENDS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    restartReq |-> (stageRun == '0)); // R4
  AST_RESTART_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(restartReq) |-> $past(stageRun[NUM_STAGES-1])); // R4
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !enState |-> (actPulse == '0) && !restartReq && (stageRun == '0)); // R10
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stopWr |=> !enState && (actPulse == '0) && !restartReq); // R10

  for (genvar g = 0; g < NUM_STAGES - 1; g++) begin : gPulse
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      actPulse[g] |=> !actPulse[g]); // R5
    AST_PULSE_STARTS_NEXT: assert property (@(posedge clk) disable iff (rst)
      actPulse[g] |-> stageRun[g+1]); // R3
  end

endmodule

bind wdog_cascade wdog_cascade_chk #(
  .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .actPulse(actPulse), .restartReq(restartReq), .stageRun(stageRun),
  .enState(enState)
);

// File: tb/wdog_cascade_tb_top.sv
module wdog_cascade_tb_top;

  localparam int N      = 3;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int DEF_P  = 1000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [N-2:0]      actPulse;
  logic              restartReq;

  always #4 clk = ~clk;  // 125 MHz

  wdog_cascade dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .actPulse(actPulse), .restartReq(restartReq)
  );

  typedef struct {
    int    cyc;
    int    idx;
    string req;
  } expItem_t;

  expItem_t sbq[$];
  int  cyc = 0;
  int  nChecks = 0;
  int  nErr = 0;
  bit  prevRestart = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic takeEvent(input int idx);
    expItem_t e;
    if (sbq.size() == 0) begin
      check(1'b0, "R3", "unexpected action from stage", idx, -1);
    end else begin
      e = sbq.pop_front();
      check(e.idx == idx, e.req, "action stage", idx, e.idx);
      check(e.cyc == cyc, e.req, "action cycle", cyc, e.cyc);
    end
  endtask

  // Monitor: compares produced actions with the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N - 1; i++) if (actPulse[i]) takeEvent(i);
      if (restartReq && !prevRestart) takeEvent(N - 1);
    end
    prevRestart = restartReq;
  end

  task automatic wr(input int a, input int d, output int edgeNo);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = CNT_W'(d);
    edgeNo = cyc + 1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPeriods(input int p0, input int p1, input int p2);
    int e;
    wr(2, p0, e); wr(3, p1, e); wr(4, p2, e);
  endtask

  // Driver: pushes the expected expiry schedule of a run started on edge s
  task automatic pushSchedule(input int s, input int p0, input int p1,
                              input int p2, input string req);
    int t;
    t = s + p0 + 1; sbq.push_back('{t, 0, req});
    t = t + p1 + 1; sbq.push_back('{t, 1, req});
    t = t + p2 + 1; sbq.push_back('{t, 2, req});
  endtask

  task automatic drain(input string req);
    int lim = 0;
    while (sbq.size() != 0 && lim < 5000) begin
      @(negedge clk); lim++;
    end
    check(sbq.size() == 0, req, "pending expected actions", sbq.size(), 0);
  endtask

  task automatic stopWd();
    int e;
    wr(0, 0, e);
  endtask

  initial begin
    int e, k, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(actPulse == '0, "R1", "actPulse after reset", actPulse, 0);
    check(restartReq == 1'b0, "R1", "restartReq after reset", restartReq, 0);

    // R1 default periods, R2 enable write starts stage 0
    wr(0, 1, e);
    pushSchedule(e, DEF_P, DEF_P, DEF_P, "R1");
    drain("R1");
    stopWd();

    // R3 R4 R5 basic cascade with distinct periods
    setPeriods(5, 3, 2);
    wr(0, 1, e);
    pushSchedule(e, 5, 3, 2, "R3");
    drain("R4");
    held = 0;
    repeat (10) begin
      @(negedge clk);
      if (restartReq) held++;
    end
    check(held == 10, "R6", "cycles restartReq held", held, 10);
    stopWd();
    // R10 disable clears restart request on the write edge
    check(restartReq == 1'b0, "R10", "restartReq after disable", restartReq, 0);

    // R8 wrong key leaves stage 0 timing unchanged
    setPeriods(6, 1, 1);
    wr(0, 1, e);
    pushSchedule(e, 6, 1, 1, "R8");
    wr(1, 'h5B, k);
    drain("R8");
    stopWd();

    // R7 valid kick reloads stage 0; R9 late kick has no effect
    setPeriods(8, 6, 2);
    wr(0, 1, e);
    repeat (3) @(negedge clk);
    wr(1, 'h5A, k);
    pushSchedule(k, 8, 6, 2, "R7");
    while (sbq.size() > 2) @(negedge clk);
    sbq[0].req = "R9"; sbq[1].req = "R9";
    wr(1, 'h5A, k);
    drain("R9");
    stopWd();

    // R10 disable mid-run: nothing fires; re-enable restarts and accepts kicks
    setPeriods(10, 2, 2);
    wr(0, 1, e);
    repeat (4) @(negedge clk);
    stopWd();
    repeat (40) @(negedge clk);
    check(actPulse == '0, "R10", "actPulse while disabled", actPulse, 0);
    check(restartReq == 1'b0, "R10", "restartReq while disabled", restartReq, 0);
    wr(0, 1, e);
    wr(1, 'h5A, k);
    pushSchedule(k, 10, 2, 2, "R10");
    drain("R10");
    stopWd();

    // R11 zero periods expire on consecutive edges
    setPeriods(0, 0, 0);
    wr(0, 1, e);
    pushSchedule(e, 0, 0, 0, "R11");
    drain("R11");
    stopWd();
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule